// File: doc/BRIEF.md
# Dual-Edge Set/Clear Flag Controller

This block turns two slow control lines into synchronous events on a single system clock. Neither line is a clock. Each line is compared with a registered copy of itself, and a rising edge on a line becomes a pulse one clock long. A pulse from the clear line drives a persistent mode flag low. A pulse from the set line drives the flag high. When both pulses fall in the same cycle, the clear wins.

The two pulses are also merged into one load strobe. During a strobe cycle a data word passes from input to output. In every other cycle the output reads zero, so downstream logic can use the word as a qualified capture.

The mode flag is held by a two-state machine with the states `MODE_CLEAR` and `MODE_SET`. It has these transitions:
- `MODE_CLEAR` to `MODE_SET` on a set pulse with no clear pulse.
- `MODE_SET` to `MODE_CLEAR` on any clear pulse.
- Every other case stays in place.

When the control lines are asynchronous to the clock, the parameter `USE_SYNC` adds a second register stage in front of the edge compare.

Top module: `dual_edge_flag`

## Requirements
- R1: With `USE_SYNC`=0, `clr_pulse` (resp. `set_pulse`) is high in a cycle exactly when `clr_req` (resp. `set_req`) is high and its value registered at the previous clock edge is low.
- R2: A pulse lasts one clock cycle even if its request line stays high.
- R3: After a clock edge at which `clr_pulse` was high, `mode_flag` is 0. After a clock edge at which only `set_pulse` was high, `mode_flag` is 1 (1 means set).
- R4: When `clr_pulse` and `set_pulse` are high in the same cycle, `mode_flag` is 0 after the edge.
- R5: After a clock edge with neither pulse high, `mode_flag` keeps its value.
- R6: `load_strobe` is high exactly when at least one of the two pulses is high.
- R7: `data_out` equals `data_in` while `load_strobe` is high and is all zeros otherwise.
- R8: `rst` is active high and asynchronous. It forces `mode_flag` to 0 without a clock edge and clears the request history registers. With both request lines low during and after reset, no pulse appears.
- R9: With `USE_SYNC`=1, each request passes through two registers. A pulse is high when the first stage is high and the second is low, so it appears one cycle later than with `USE_SYNC`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous active-high reset |
| clr_req | input | 1 | Control line whose rising edge clears the flag |
| set_req | input | 1 | Control line whose rising edge sets the flag |
| data_in | input | DATA_W | Word passed through on a strobe |
| mode_flag | output | 1 | Persistent mode flag, 1 = set |
| clr_pulse | output | 1 | One-cycle pulse on a clear-line rising edge |
| set_pulse | output | 1 | One-cycle pulse on a set-line rising edge |
| load_strobe | output | 1 | OR of the two pulses |
| data_out | output | DATA_W | `data_in` during a strobe, zero otherwise |

## Verification
The hardest case to reach is two rising edges arriving in the same cycle while the flag is already set, because only that case exercises the clear-over-set priority from the set state. The stimulus covers every ordered pair of consecutive request vectors, and each pair starts from both flag values. This guarantees simultaneous edges from the set state and held-high lines that must not pulse again. The same sweep drives a second copy built with the synchronizer, which is checked against its own two-stage model. A reset raised between clock edges confirms that the flag drops without waiting for a clock.

// File: rtl/dual_edge_flag_pkg.sv
package dual_edge_flag_pkg;
    typedef enum logic {
        MODE_CLEAR = 1'b0,
        MODE_SET   = 1'b1
    } mode_state_t;
endpackage

// File: rtl/edge_sense.sv
module edge_sense #(
    parameter bit USE_SYNC = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic pulse
);
    generate
        if (USE_SYNC) begin : g_sync
            logic stage_a;
            logic stage_b;
            always_ff @(posedge clk or posedge rst) begin
                if (rst) begin
                    stage_a <= 1'b0;
                    stage_b <= 1'b0;
                end else begin
                    stage_a <= req;
                    stage_b <= stage_a;
                end
            end
            assign pulse = stage_a & ~stage_b;
        end else begin : g_direct
            logic last_q;
            always_ff @(posedge clk or posedge rst) begin
                if (rst) begin
                    last_q <= 1'b0;
                end else begin
                    last_q <= req;
                end
            end
            assign pulse = req & ~last_q;
        end
    endgenerate
endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
    import dual_edge_flag_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr_ev,
    input  logic set_ev,
    output logic flag
);
    mode_state_t state_q;
    mode_state_t state_d;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= MODE_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_CLEAR: if (set_ev && !clr_ev) state_d = MODE_SET;
            MODE_SET:   if (clr_ev)            state_d = MODE_CLEAR;
            default:    state_d = MODE_CLEAR;
        endcase
    end

    always_comb begin
        unique case (state_q)
            MODE_SET: flag = 1'b1;
            default:  flag = 1'b0;
        endcase
    end
endmodule

// File: rtl/data_gate.sv
module data_gate #(
    parameter int DATA_W = 8
) (
    input  logic              ev_a,
    input  logic              ev_b,
    input  logic [DATA_W-1:0] din,
    output logic              strobe,
    output logic [DATA_W-1:0] dout
);
    localparam logic [DATA_W-1:0] ZERO_WORD = '0;

    always_comb begin
        strobe = ev_a | ev_b;
        dout   = strobe ? din : ZERO_WORD;
    end
endmodule

// File: rtl/dual_edge_flag.sv
module dual_edge_flag #(
    parameter int DATA_W   = 8,
    parameter bit USE_SYNC = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_req,
    input  logic              set_req,
    input  logic [DATA_W-1:0] data_in,
    output logic              mode_flag,
    output logic              clr_pulse,
    output logic              set_pulse,
    output logic              load_strobe,
    output logic [DATA_W-1:0] data_out
);
    edge_sense #(.USE_SYNC(USE_SYNC)) u_clr_edge (
        .clk   (clk),
        .rst   (rst),
        .req   (clr_req),
        .pulse (clr_pulse)
    );

    edge_sense #(.USE_SYNC(USE_SYNC)) u_set_edge (
        .clk   (clk),
        .rst   (rst),
        .req   (set_req),
        .pulse (set_pulse)
    );

    mode_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .clr_ev (clr_pulse),
        .set_ev (set_pulse),
        .flag   (mode_flag)
    );

    data_gate #(.DATA_W(DATA_W)) u_gate (
        .ev_a   (clr_pulse),
        .ev_b   (set_pulse),
        .din    (data_in),
        .strobe (load_strobe),
        .dout   (data_out)
    );
endmodule

// File: rtl/dual_edge_flag_chk.sv
module dual_edge_flag_chk #(
    parameter int DATA_W   = 8,
    parameter bit USE_SYNC = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic              clr_pulse,
    input logic              set_pulse,
    input logic              load_strobe,
    input logic              mode_flag,
    input logic [DATA_W-1:0] data_in,
    input logic [DATA_W-1:0] data_out
);
    p_clr_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
        clr_pulse |=> !clr_pulse);
    p_set_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
        set_pulse |=> !set_pulse);
    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
        clr_pulse |=> !mode_flag);
    p_set_r3: assert property (@(posedge clk) disable iff (rst)
        (set_pulse && !clr_pulse) |=> mode_flag);
    p_both_clear_wins_r4: assert property (@(posedge clk) disable iff (rst)
        (set_pulse && clr_pulse) |=> !mode_flag);
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!set_pulse && !clr_pulse) |=> $stable(mode_flag));
    p_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        load_strobe |-> (clr_pulse || set_pulse));
    p_pass_r7: assert property (@(posedge clk) disable iff (rst)
        (clr_pulse || set_pulse) |-> (data_out == data_in));
    p_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (!clr_pulse && !set_pulse) |-> (data_out == '0));
endmodule

bind dual_edge_flag dual_edge_flag_chk #(.DATA_W(DATA_W), .USE_SYNC(USE_SYNC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .clr_pulse   (clr_pulse),
    .set_pulse   (set_pulse),
    .load_strobe (load_strobe),
    .mode_flag   (mode_flag),
    .data_in     (data_in),
    .data_out    (data_out)
);

// File: tb/sim_dual_edge_flag.sv
module sim_dual_edge_flag;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clr_req = 1'b0;
    logic          set_req = 1'b0;
    logic [DW-1:0] data_in = '0;

    logic          m0, c0, s0, l0;
    logic [DW-1:0] d0;
    logic          m1, c1, s1, l1;
    logic [DW-1:0] d1;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // models
    bit pc, ps;            // direct history
    bit mode0;
    bit ac, bc, as_, bs;   // sync stages
    bit mode1;
    int step_no = 0;

    always #5 clk = ~clk;

    dual_edge_flag #(.DATA_W(DW), .USE_SYNC(1'b0)) u0 (
        .clk(clk), .rst(rst), .clr_req(clr_req), .set_req(set_req), .data_in(data_in),
        .mode_flag(m0), .clr_pulse(c0), .set_pulse(s0), .load_strobe(l0), .data_out(d0));

    dual_edge_flag #(.DATA_W(DW), .USE_SYNC(1'b1)) u1 (
        .clk(clk), .rst(rst), .clr_req(clr_req), .set_req(set_req), .data_in(data_in),
        .mode_flag(m1), .clr_pulse(c1), .set_pulse(s1), .load_strobe(l1), .data_out(d1));

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d (step %0d)", req, what, act, exp, step_no);
        end
    endtask

    task automatic model_reset();
        pc = 0; ps = 0; mode0 = 0;
        ac = 0; bc = 0; as_ = 0; bs = 0; mode1 = 0;
    endtask

    // drive one vector after a falling edge, check, then advance models past the next rising edge
    task automatic apply(input bit c, input bit s);
        bit ec0, es0, ec1, es1;
        logic [DW-1:0] dv;
        @(negedge clk);
        step_no++;
        dv = DW'((step_no * 37 + 5) & 8'hFF);
        clr_req = c;
        set_req = s;
        data_in = dv;
        #2;
        ec0 = c & ~pc;
        es0 = s & ~ps;
        ec1 = ac & ~bc;
        es1 = as_ & ~bs;
        check("R1", "u0 clr_pulse", int'(c0), int'(ec0));
        check("R1", "u0 set_pulse", int'(s0), int'(es0));
        check("R3", "u0 mode_flag", int'(m0), int'(mode0));
        check("R6", "u0 load_strobe", int'(l0), int'(ec0 | es0));
        check("R7", "u0 data_out", int'(d0), (ec0 | es0) ? int'(dv) : 0);
        check("R9", "u1 clr_pulse", int'(c1), int'(ec1));
        check("R9", "u1 set_pulse", int'(s1), int'(es1));
        check("R4", "u1 mode_flag", int'(m1), int'(mode1));
        check("R7", "u1 data_out", int'(d1), (ec1 | es1) ? int'(dv) : 0);
        // posedge update: clear wins (R4), otherwise hold (R5)
        if (ec0) mode0 = 0; else if (es0) mode0 = 1;
        if (ec1) mode1 = 0; else if (es1) mode1 = 1;
        pc = c; ps = s;
        bc = ac; bs = as_; ac = c; as_ = s;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #2;
        check("R8", "u0 mode_flag in reset", int'(m0), 0);
        check("R8", "u0 load_strobe in reset", int'(l0), 0);
        check("R8", "u1 mode_flag in reset", int'(m1), 0);
        @(negedge clk);
        rst = 1'b0;

        // every ordered pair of consecutive vectors from both flag values (R2, R4, R5)
        for (int m = 0; m < 2; m++) begin
            for (int p = 0; p < 4; p++) begin
                for (int q = 0; q < 4; q++) begin
                    apply(0, 0); apply(0, 0);
                    if (m == 1) begin apply(0, 1); apply(0, 1); end
                    else        begin apply(1, 0); apply(1, 0); end
                    apply(0, 0); apply(0, 0);
                    apply(p[1], p[0]);
                    apply(q[1], q[0]);
                    apply(q[1], q[0]);
                    apply(q[1], q[0]);
                end
            end
        end

        // asynchronous reset between edges (R8)
        apply(0, 0); apply(0, 1); apply(0, 1); apply(0, 1);
        check("R8", "u0 flag set before reset", int'(m0), 1);
        @(negedge clk);
        clr_req = 0; set_req = 0;
        #1 rst = 1'b1;
        #1;
        check("R8", "u0 flag async clear", int'(m0), 0);
        check("R8", "u1 flag async clear", int'(m1), 0);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        apply(0, 0);
        apply(0, 0);
        apply(1, 1);
        apply(0, 0);
        apply(0, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule